// File: doc/BRIEF.md
# Split-Transaction Outstanding Request Table

Each node on a split-transaction bus carries its request on one group of lines and receives the reply later on a separate group. Between those two events it holds nothing on the bus. This table keeps track of every transaction that is still in flight. Every node holds an identical copy and keeps it current by watching all requests and all responses. When a request is seen, the table stores it in the lowest-numbered free slot. The slot index is the tag that the matching response carries back. When that response is seen, the slot is freed.

On the local side, a cache controller presents a candidate request each cycle. The table gives one of three answers. If nothing in flight touches that block, the controller may arbitrate for the bus. If the request is a read and a read to that block is already pending, the controller joins that transaction instead of issuing its own. In all other cases it must hold back. When a response frees an entry, the table reports which local waiters joined that entry and whether this node issued the original request. The data path for the response is outside this block.

Top module: `rqt_table`

## Requirements
- R1: After reset every slot is empty. A local request to any block is then allowed to issue, and the next allocation tag is 0.
- R2: A snooped bus request takes the lowest-numbered empty slot. In the same cycle, `alloc_ok`=1 and `alloc_tag` shows that slot's index. The slot is occupied from the following clock edge.
- R3: A response whose tag names an occupied slot frees that slot at the next edge. In the same cycle, `wake_valid`=1, `wake_mask` shows the slot's waiter bits, and `wake_own` shows whether the slot's originating node ID equals the node's own ID.
- R4: A local request to a block with a pending entry is blocked (`lreq_may_issue`=0, `lreq_merge`=0) if either the local request or the pending entry is a write (`*_write`=1).
- R5: A local read (`lreq_write`=0) to a block with a pending read gives `lreq_merge`=1, `lreq_may_issue`=0 and `lreq_merge_tag` = that slot. From the next edge, bit `lreq_port` of the slot's waiter mask is set.
- R6: If a bus request to the same block address appears in the same cycle as a local request, the local request neither issues nor merges.
- R7: When all slots are occupied, a local request that matches no entry is refused (`lreq_may_issue`=0). A bus request seen while the table is full is not stored (`alloc_ok`=0).
- R8: A slot that is being freed in the current cycle does not count as a match for a local request in that cycle.
- R9: A response whose tag names an empty slot has no effect. `wake_valid` stays 0 and the table contents are unchanged.
- R10: Waiter bits from several local ports accumulate on one slot, and all of them are reported together when the response arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| breq_valid | input | 1 | A request is observed on the bus request lines |
| breq_addr | input | ADDR_W | Block address of the observed request |
| breq_write | input | 1 | Observed request is exclusive/write (1) or read (0) |
| breq_node | input | NODE_W | Originating node ID of the observed request |
| alloc_ok | output | 1 | The observed request is being stored this cycle |
| alloc_tag | output | TAG_W | Slot index (tag) given to the observed request |
| bresp_valid | input | 1 | A response is observed on the response lines |
| bresp_tag | input | TAG_W | Tag carried by the response |
| wake_valid | output | 1 | The response frees an occupied slot |
| wake_mask | output | WAITERS | Local waiter bits of the freed slot |
| wake_own | output | 1 | The freed slot was issued by this node |
| lreq_valid | input | 1 | Local candidate request present |
| lreq_addr | input | ADDR_W | Block address of the local request |
| lreq_write | input | 1 | Local request is a write (1) or read (0) |
| lreq_port | input | PORT_W | Index of the local waiter making the request |
| lreq_may_issue | output | 1 | Local request may arbitrate for the bus |
| lreq_merge | output | 1 | Local read joins a pending read |
| lreq_merge_tag | output | TAG_W | Slot joined when merging |

## Verification
A wrong slot state shows up at the ports quickly. A slot that stays occupied after its response produces a wrong `alloc_tag` on the next bus request, or a blocked local request to that block. A lost waiter bit shows as a wrong `wake_mask` in the response cycle. A wrong occupancy count shows as `lreq_may_issue` or `alloc_ok` being wrong on the first request after it. The directed sequences are arranged so that each such fault surfaces within a few cycles of the stimulus that caused it.

// File: rtl/rqt_pkg.sv
package rqt_pkg;
  typedef enum logic {
    RK_READ  = 1'b0,
    RK_WRITE = 1'b1
  } rqt_kind_e;
endpackage

// File: rtl/rqt_pick.sv
// Lowest-index one finder over a request vector.
module rqt_pick #(
  parameter int N = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic [IW-1:0] idx,
  output logic          any
);
  always_comb begin
    idx = '0;
    any = |req;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/rqt_match.sv
// Parallel block-address comparison against all live slots.
module rqt_match #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 32
) (
  input  logic [DEPTH-1:0]             live,
  input  logic [DEPTH-1:0][ADDR_W-1:0] slot_addr,
  input  logic [ADDR_W-1:0]            key,
  output logic [DEPTH-1:0]             hit
);
  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign hit[g] = live[g] && (slot_addr[g] == key);
  end
endmodule

// File: rtl/rqt_entry.sv
// One slot of the outstanding request table.
module rqt_entry
  import rqt_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int NODE_W  = 4,
  parameter int WAITERS = 4,
  localparam int PORT_W = (WAITERS > 1) ? $clog2(WAITERS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_en,
  input  logic [ADDR_W-1:0] alloc_addr,
  input  rqt_kind_e         alloc_kind,
  input  logic [NODE_W-1:0] alloc_node,
  input  logic              free_en,
  input  logic              merge_en,
  input  logic [PORT_W-1:0] merge_port,
  output logic              valid_o,
  output logic [ADDR_W-1:0] addr_o,
  output rqt_kind_e         kind_o,
  output logic [NODE_W-1:0] node_o,
  output logic [WAITERS-1:0] mask_o
);
  logic               valid_q, valid_d;
  logic [WAITERS-1:0] mask_q, mask_d;
  logic [ADDR_W-1:0]  addr_q;
  rqt_kind_e          kind_q;
  logic [NODE_W-1:0]  node_q;

  always_comb begin
    valid_d = valid_q;
    mask_d  = mask_q;
    if (free_en) begin
      valid_d = 1'b0;
      mask_d  = '0;
    end else if (alloc_en) begin
      valid_d = 1'b1;
      mask_d  = '0;
    end else if (merge_en) begin
      mask_d = mask_q | (WAITERS'(1) << merge_port);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      mask_q  <= '0;
    end else begin
      valid_q <= valid_d;
      mask_q  <= mask_d;
    end
  end

  // Payload fields load only on allocation (clock enable).
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      kind_q <= RK_READ;
      node_q <= '0;
    end else if (alloc_en) begin
      addr_q <= alloc_addr;
      kind_q <= alloc_kind;
      node_q <= alloc_node;
    end
  end

  assign valid_o = valid_q;
  assign addr_o  = addr_q;
  assign kind_o  = kind_q;
  assign node_o  = node_q;
  assign mask_o  = mask_q;
endmodule

// File: rtl/rqt_table.sv
module rqt_table
  import rqt_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DEPTH   = 8,
  parameter int NODE_W  = 4,
  parameter int WAITERS = 4,
  parameter int MY_NODE = 1,
  localparam int TAG_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int PORT_W = (WAITERS > 1) ? $clog2(WAITERS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               breq_valid,
  input  logic [ADDR_W-1:0]  breq_addr,
  input  logic               breq_write,
  input  logic [NODE_W-1:0]  breq_node,
  output logic               alloc_ok,
  output logic [TAG_W-1:0]   alloc_tag,
  input  logic               bresp_valid,
  input  logic [TAG_W-1:0]   bresp_tag,
  output logic               wake_valid,
  output logic [WAITERS-1:0] wake_mask,
  output logic               wake_own,
  input  logic               lreq_valid,
  input  logic [ADDR_W-1:0]  lreq_addr,
  input  logic               lreq_write,
  input  logic [PORT_W-1:0]  lreq_port,
  output logic               lreq_may_issue,
  output logic               lreq_merge,
  output logic [TAG_W-1:0]   lreq_merge_tag
);
  localparam logic [NODE_W-1:0] OWN_ID = NODE_W'(MY_NODE);

  logic [DEPTH-1:0]               valid_vec;
  logic [DEPTH-1:0][ADDR_W-1:0]   addr_arr;
  rqt_kind_e                      kind_arr [DEPTH];
  logic [DEPTH-1:0][NODE_W-1:0]   node_arr;
  logic [DEPTH-1:0][WAITERS-1:0]  mask_arr;

  logic [DEPTH-1:0] alloc_dec, free_dec, merge_dec, live_vec, hit_vec;
  logic [TAG_W-1:0] free_idx, hit_idx;
  logic             slot_free, hit_any, hit_is_read, resp_hit, bus_clash, table_full;
  rqt_kind_e        breq_kind;

  assign breq_kind = breq_write ? RK_WRITE : RK_READ;

  // Slot selection for snooped requests: lowest empty index.
  rqt_pick #(.N(DEPTH)) u_free_pick (
    .req (~valid_vec),
    .idx (free_idx),
    .any (slot_free)
  );

  assign alloc_ok  = breq_valid && slot_free;
  assign alloc_tag = free_idx;

  // Response decode.
  always_comb begin
    resp_hit  = 1'b0;
    wake_mask = '0;
    wake_own  = 1'b0;
    if (bresp_valid && (int'(bresp_tag) < DEPTH)) begin
      resp_hit = valid_vec[bresp_tag];
      if (resp_hit) begin
        wake_mask = mask_arr[bresp_tag];
        wake_own  = (node_arr[bresp_tag] == OWN_ID);
      end
    end
  end
  assign wake_valid = resp_hit;

  // Local lookup excludes slots being freed this cycle.
  assign live_vec = valid_vec & ~free_dec;

  rqt_match #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_match (
    .live      (live_vec),
    .slot_addr (addr_arr),
    .key       (lreq_addr),
    .hit       (hit_vec)
  );

  rqt_pick #(.N(DEPTH)) u_hit_pick (
    .req (hit_vec),
    .idx (hit_idx),
    .any (hit_any)
  );

  assign hit_is_read    = (kind_arr[hit_idx] == RK_READ);
  assign bus_clash      = breq_valid && (breq_addr == lreq_addr);
  assign table_full     = &valid_vec;
  assign lreq_merge     = lreq_valid && !lreq_write && hit_any && hit_is_read && !bus_clash;
  assign lreq_may_issue = lreq_valid && !hit_any && !bus_clash && !table_full;
  assign lreq_merge_tag = hit_idx;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    assign alloc_dec[g] = alloc_ok && (free_idx == TAG_W'(g));
    assign free_dec[g]  = resp_hit && (bresp_tag == TAG_W'(g));
    assign merge_dec[g] = lreq_merge && (hit_idx == TAG_W'(g));

    rqt_entry #(
      .ADDR_W  (ADDR_W),
      .NODE_W  (NODE_W),
      .WAITERS (WAITERS)
    ) u_entry (
      .clk        (clk),
      .rst_n      (rst_n),
      .alloc_en   (alloc_dec[g]),
      .alloc_addr (breq_addr),
      .alloc_kind (breq_kind),
      .alloc_node (breq_node),
      .free_en    (free_dec[g]),
      .merge_en   (merge_dec[g]),
      .merge_port (lreq_port),
      .valid_o    (valid_vec[g]),
      .addr_o     (addr_arr[g]),
      .kind_o     (kind_arr[g]),
      .node_o     (node_arr[g]),
      .mask_o     (mask_arr[g])
    );
  end
endmodule

// File: rtl/rqt_table_chk.sv
module rqt_table_chk #(
  parameter int DEPTH   = 8,
  parameter int WAITERS = 4,
  parameter int ADDR_W  = 32,
  localparam int TAG_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int PORT_W = (WAITERS > 1) ? $clog2(WAITERS) : 1
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          breq_valid,
  input logic [ADDR_W-1:0]             breq_addr,
  input logic                          alloc_ok,
  input logic [TAG_W-1:0]              alloc_tag,
  input logic                          bresp_valid,
  input logic [TAG_W-1:0]              bresp_tag,
  input logic                          wake_valid,
  input logic                          lreq_valid,
  input logic [ADDR_W-1:0]             lreq_addr,
  input logic [PORT_W-1:0]             lreq_port,
  input logic                          lreq_may_issue,
  input logic                          lreq_merge,
  input logic [TAG_W-1:0]              lreq_merge_tag,
  input logic [DEPTH-1:0]              valid_vec,
  input logic [DEPTH-1:0][WAITERS-1:0] mask_arr
);
  a_r2_alloc_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_ok |=> valid_vec[$past(alloc_tag)]);

  a_r3_resp_frees: assert property (@(posedge clk) disable iff (!rst_n)
    wake_valid |=> !valid_vec[$past(bresp_tag)]);

  a_r5_merge_marks: assert property (@(posedge clk) disable iff (!rst_n)
    lreq_merge |=> mask_arr[$past(lreq_merge_tag)][$past(lreq_port)]);

  a_r5_issue_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(lreq_may_issue && lreq_merge));

  a_r6_bus_clash: assert property (@(posedge clk) disable iff (!rst_n)
    (lreq_valid && breq_valid && breq_addr == lreq_addr) |-> (!lreq_may_issue && !lreq_merge));

  a_r7_full_refuse: assert property (@(posedge clk) disable iff (!rst_n)
    (&valid_vec) |-> (!lreq_may_issue && !alloc_ok));

  a_r9_empty_resp: assert property (@(posedge clk) disable iff (!rst_n)
    (bresp_valid && !valid_vec[bresp_tag]) |-> !wake_valid);
endmodule

bind rqt_table rqt_table_chk #(
  .DEPTH   (DEPTH),
  .WAITERS (WAITERS),
  .ADDR_W  (ADDR_W)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .breq_valid     (breq_valid),
  .breq_addr      (breq_addr),
  .alloc_ok       (alloc_ok),
  .alloc_tag      (alloc_tag),
  .bresp_valid    (bresp_valid),
  .bresp_tag      (bresp_tag),
  .wake_valid     (wake_valid),
  .lreq_valid     (lreq_valid),
  .lreq_addr      (lreq_addr),
  .lreq_port      (lreq_port),
  .lreq_may_issue (lreq_may_issue),
  .lreq_merge     (lreq_merge),
  .lreq_merge_tag (lreq_merge_tag),
  .valid_vec      (valid_vec),
  .mask_arr       (mask_arr)
);

// File: tb/rqt_table_bench.sv
`timescale 1ns/1ps
module rqt_table_bench;
  localparam int AW = 32;
  localparam int TW = 3;
  localparam int WT = 4;
  localparam int PW = 2;
  localparam int NW = 4;

  logic          clk, rst_n;
  logic          breq_valid, breq_write;
  logic [AW-1:0] breq_addr;
  logic [NW-1:0] breq_node;
  logic          alloc_ok;
  logic [TW-1:0] alloc_tag;
  logic          bresp_valid;
  logic [TW-1:0] bresp_tag;
  logic          wake_valid, wake_own;
  logic [WT-1:0] wake_mask;
  logic          lreq_valid, lreq_write;
  logic [AW-1:0] lreq_addr;
  logic [PW-1:0] lreq_port;
  logic          lreq_may_issue, lreq_merge;
  logic [TW-1:0] lreq_merge_tag;

  int total = 0;
  int bad   = 0;

  rqt_table #(.ADDR_W(AW), .DEPTH(8), .NODE_W(NW), .WAITERS(WT), .MY_NODE(1)) u_rqt_table (
    .clk(clk), .rst_n(rst_n),
    .breq_valid(breq_valid), .breq_addr(breq_addr), .breq_write(breq_write), .breq_node(breq_node),
    .alloc_ok(alloc_ok), .alloc_tag(alloc_tag),
    .bresp_valid(bresp_valid), .bresp_tag(bresp_tag),
    .wake_valid(wake_valid), .wake_mask(wake_mask), .wake_own(wake_own),
    .lreq_valid(lreq_valid), .lreq_addr(lreq_addr), .lreq_write(lreq_write), .lreq_port(lreq_port),
    .lreq_may_issue(lreq_may_issue), .lreq_merge(lreq_merge), .lreq_merge_tag(lreq_merge_tag)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(string rq, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic idle();
    breq_valid = 0; breq_addr = '0; breq_write = 0; breq_node = '0;
    bresp_valid = 0; bresp_tag = '0;
    lreq_valid = 0; lreq_addr = '0; lreq_write = 0; lreq_port = '0;
  endtask

  task automatic bus_req(string rq, logic [AW-1:0] a, logic wr, logic [NW-1:0] nd,
                         logic exp_ok, logic [TW-1:0] exp_tag);
    @(negedge clk);
    breq_valid = 1; breq_addr = a; breq_write = wr; breq_node = nd;
    #1;
    check(rq, "alloc_ok", 32'(alloc_ok), 32'(exp_ok));
    if (exp_ok) check(rq, "alloc_tag", 32'(alloc_tag), 32'(exp_tag));
    @(posedge clk); #0.1;
    idle();
  endtask

  task automatic resp(string rq, logic [TW-1:0] t, logic exp_wake, logic [WT-1:0] exp_mask, logic exp_own);
    @(negedge clk);
    bresp_valid = 1; bresp_tag = t;
    #1;
    check(rq, "wake_valid", 32'(wake_valid), 32'(exp_wake));
    if (exp_wake) begin
      check(rq, "wake_mask", 32'(wake_mask), 32'(exp_mask));
      check(rq, "wake_own", 32'(wake_own), 32'(exp_own));
    end
    @(posedge clk); #0.1;
    idle();
  endtask

  task automatic local_q(string rq, logic [AW-1:0] a, logic wr, logic [PW-1:0] p,
                         logic exp_issue, logic exp_merge, logic [TW-1:0] exp_tag);
    @(negedge clk);
    lreq_valid = 1; lreq_addr = a; lreq_write = wr; lreq_port = p;
    #1;
    check(rq, "may_issue", 32'(lreq_may_issue), 32'(exp_issue));
    check(rq, "merge", 32'(lreq_merge), 32'(exp_merge));
    if (exp_merge) check(rq, "merge_tag", 32'(lreq_merge_tag), 32'(exp_tag));
    @(posedge clk); #0.1;
    idle();
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1", "alloc_tag", 32'(alloc_tag), 0);
    local_q("R1", 32'h100, 0, 0, 1, 0, 0);
  endtask

  task automatic t_alloc();
    bus_req("R2", 32'h100, 0, 2, 1, 0);
    bus_req("R2", 32'h200, 1, 1, 1, 1);
    bus_req("R2", 32'h300, 0, 3, 1, 2);
  endtask

  task automatic t_block();
    local_q("R4", 32'h100, 1, 0, 0, 0, 0);
    local_q("R4", 32'h200, 0, 0, 0, 0, 0);
  endtask

  task automatic t_merge();
    local_q("R5", 32'h100, 0, 1, 0, 1, 0);
    local_q("R10", 32'h100, 0, 3, 0, 1, 0);
    resp("R10", 0, 1, 4'b1010, 0);
    local_q("R3", 32'h100, 0, 0, 1, 0, 0);
    resp("R3", 1, 1, 4'b0000, 1);
  endtask

  task automatic t_empty_resp();
    resp("R9", 5, 0, 4'b0000, 0);
    bus_req("R9", 32'h400, 1, 2, 1, 0);
    bus_req("R2", 32'h500, 0, 1, 1, 1);
  endtask

  task automatic t_collide();
    @(negedge clk);
    breq_valid = 1; breq_addr = 32'h600; breq_write = 0; breq_node = 4;
    lreq_valid = 1; lreq_addr = 32'h600; lreq_write = 0; lreq_port = 2;
    #1;
    check("R6", "may_issue", 32'(lreq_may_issue), 0);
    check("R6", "merge", 32'(lreq_merge), 0);
    check("R2", "alloc_tag", 32'(alloc_tag), 3);
    @(posedge clk); #0.1;
    idle();
    local_q("R5", 32'h600, 0, 2, 0, 1, 3);
  endtask

  task automatic t_full();
    bus_req("R2", 32'h700, 0, 2, 1, 4);
    bus_req("R2", 32'h800, 0, 2, 1, 5);
    bus_req("R2", 32'h900, 1, 2, 1, 6);
    bus_req("R2", 32'hA00, 0, 2, 1, 7);
    local_q("R7", 32'hB00, 0, 0, 0, 0, 0);
    bus_req("R7", 32'hB00, 0, 2, 0, 0);
    resp("R3", 5, 1, 4'b0000, 0);
    // R8: slot 6 freed in the same cycle as a local write to its block
    @(negedge clk);
    bresp_valid = 1; bresp_tag = 6;
    lreq_valid = 1; lreq_addr = 32'h900; lreq_write = 1; lreq_port = 0;
    #1;
    check("R8", "wake_valid", 32'(wake_valid), 1);
    check("R8", "may_issue", 32'(lreq_may_issue), 1);
    check("R8", "merge", 32'(lreq_merge), 0);
    @(posedge clk); #0.1;
    idle();
    local_q("R8", 32'h900, 0, 0, 1, 0, 0);
    bus_req("R7", 32'hC00, 0, 2, 1, 5);
    resp("R5", 3, 1, 4'b0100, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle();
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    t_reset();
    t_alloc();
    t_block();
    t_merge();
    t_empty_resp();
    t_collide();
    t_full();
    repeat (2) @(posedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule